// File: doc/BRIEF.md
# Watermark-Requesting Transmit FIFO

This block buffers outgoing words for a serial port. A CPU or DMA master writes 32-bit words into a 16-entry queue, one whole entry per accepted write cycle. A serial shifter pops words from the head of the queue through a simple pop strobe. The head word is always visible on the read data output.

The block asks for more data with a level request. A 3-bit threshold code sets how many free entries must exist before the request rises, so the master can move data in bursts of 1, 4, 8, 12 or 16 words. The most eager code, which requests on any free entry, is not allowed while a DMA master services the request. When that combination is selected, the request is held low and a sticky configuration error is raised. Sticky overflow and underflow flags record writes into a full queue and pops from an empty one. The block reports the number of used entries and the number of free entries.

The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `wmf_tx_fifo`

## Requirements
- R1: After reset the used count is 0, the free count is 16, the read data is 0, and the overflow, underflow and configuration-error flags are all low.
- R2: A write cycle into a queue that is not full stores the whole 32-bit word as one entry. The used count then rises by one and the free count falls by one at the next clock edge, and used plus free always equals 16.
- R3: Words leave in the order they were written. The read data shows the oldest stored word, and a pop on a non-empty queue removes that word at the next clock edge.
- R4: A write and a pop in the same cycle on a queue that is neither empty nor full leave the counts unchanged. On an empty queue the write is accepted and the pop is an underflow. On a full queue the pop is accepted and the write is dropped as an overflow.
- R5: With threshold code 000, 001, 010 or 011, the request is high only when all 16 entries are free.
- R6: With code 100 the request is high when 12 or more entries are free. With code 101 it is high at 8 or more. With code 110 it is high at 4 or more.
- R7: With code 111 and the DMA-mode input low, the request is high whenever at least one entry is free.
- R8: With code 111 and the DMA-mode input high, the request is low. The configuration-error flag is set at the next edge and stays set until a clear pulse.
- R9: A write when the queue is full is dropped, leaves the stored words unchanged, and sets the sticky overflow flag at the next edge.
- R10: A pop when the queue is empty shows read data 0, leaves the counts unchanged, and sets the sticky underflow flag at the next edge.
- R11: A clear pulse lowers all three error flags at the next edge, except a flag whose error condition occurs in the same cycle. A new error takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one entry per cycle |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Pop strobe from the serial shifter |
| rd_data | output | 32 | Oldest stored word, 0 when the queue is empty |
| wm_code | input | 3 | Free-space threshold code for the request |
| dma_mode | input | 1 | High when a DMA master services the request |
| err_clear | input | 1 | Clears the sticky error flags |
| tx_req | output | 1 | Transmit data request (level) |
| used_cnt | output | 5 | Number of occupied entries |
| free_cnt | output | 5 | Number of empty entries |
| overflow | output | 1 | Sticky: a write hit a full queue |
| underflow | output | 1 | Sticky: a pop hit an empty queue |
| config_error | output | 1 | Sticky: code 111 selected while DMA mode is high |

## Verification
The bench builds the block with its default parameters: a depth of 16 entries and a width of 32 bits. At this depth the five request thresholds (16, 12, 8, 4 and 1 free) are all distinct, and each one is crossed in both directions. A few dozen writes or pops reach both the full and the empty boundary, so overflow, underflow, and simultaneous write and pop at each boundary happen often during the random stretch. A queue-based model predicts every output on every clock while the threshold code, the DMA-mode input and the clear pulse change freely.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

  // Threshold code that requests on any free entry; barred under DMA service.
  localparam logic [2:0] WM_ANY_FREE = 3'b111;

  // Free entries needed before the request rises, for a queue of the given depth.
  function automatic int unsigned wm_threshold(input logic [2:0] code,
                                               input int unsigned depth);
    case (code)
      3'b100:  return depth - depth / 4;
      3'b101:  return depth / 2;
      3'b110:  return depth / 4;
      3'b111:  return 1;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/wmf_storage.sv
module wmf_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0]  wptr_q, wptr_d;
  logic [PTR_W-1:0]  rptr_q, rptr_d;
  logic [DATA_W-1:0] mem_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push) wptr_d = ptr_inc(wptr_q);
    if (pop)  rptr_d = ptr_inc(rptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  // One whole entry written per accepted cycle (R2); no reset on the data array.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && (wptr_q == PTR_W'(i))) mem_q[i] <= wr_data;
    end
  end

  assign head_data = mem_q[rptr_q];

  // R3: the read pointer moves only on an accepted pop.
  a_r3_rptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> $stable(rptr_q));

endmodule

// File: rtl/wmf_level.sv
module wmf_level #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  output logic [$clog2(DEPTH+1)-1:0]   free_cnt,
  output logic [$clog2(DEPTH+1)-1:0]   used_cnt,
  output logic                         full,
  output logic                         empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] free_q, free_d;

  always_comb begin
    free_d = free_q;
    case ({push, pop})
      2'b10:   free_d = free_q - 1'b1;
      2'b01:   free_d = free_q + 1'b1;
      default: free_d = free_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= CNT_W'(DEPTH);
    else        free_q <= free_d;
  end

  assign free_cnt = free_q;
  assign used_cnt = CNT_W'(DEPTH) - free_q;
  assign full     = (free_q == '0);
  assign empty    = (free_q == CNT_W'(DEPTH));

  // R2: the free count never exceeds the depth.
  a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= CNT_W'(DEPTH));
  // R2: a lone accepted write takes exactly one free entry.
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> free_q == $past(free_q) - 1'b1);
  // R4: an accepted write and pop together hold the count.
  a_r4_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(free_q));

endmodule

// File: rtl/wmf_request.sv
module wmf_request #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] free_cnt,
  input  logic [2:0]                 wm_code,
  input  logic                       dma_mode,
  input  logic                       err_clear,
  input  logic                       ovf_evt,
  input  logic                       unf_evt,
  output logic                       tx_req,
  output logic                       overflow,
  output logic                       underflow,
  output logic                       config_error
);
  import wmf_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] thresh;
  logic             cfg_bad;
  logic             ovf_q, ovf_d, unf_q, unf_d, cfg_q, cfg_d;

  always_comb begin
    thresh  = CNT_W'(wm_threshold(wm_code, DEPTH));
    cfg_bad = dma_mode && (wm_code == WM_ANY_FREE);
    tx_req  = !cfg_bad && (free_cnt >= thresh);
  end

  // Sticky flags; a new event wins over a clear in the same cycle (R11).
  always_comb begin
    ovf_d = ovf_evt | (ovf_q & ~err_clear);
    unf_d = unf_evt | (unf_q & ~err_clear);
    cfg_d = cfg_bad | (cfg_q & ~err_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      cfg_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      cfg_q <= cfg_d;
    end
  end

  assign overflow     = ovf_q;
  assign underflow    = unf_q;
  assign config_error = cfg_q;

  // R5: codes with a clear top bit request only on a completely free queue.
  a_r5_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wm_code[2] && tx_req |-> free_cnt == CNT_W'(DEPTH));
  // R6: the half-depth code never requests below half free.
  a_r6_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_code == 3'b101) && tx_req |-> free_cnt >= CNT_W'(DEPTH / 2));
  // R7: any free entry requests when DMA mode is off.
  a_r7_any: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_code == 3'b111) && !dma_mode && (free_cnt != '0) |-> tx_req);
  // R8: the barred combination raises the configuration error.
  a_r8_cfg_set: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode && (wm_code == 3'b111) |=> config_error);
  // R11: flags hold without a clear.
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !err_clear |=> overflow);

endmodule

// File: rtl/wmf_tx_fifo.sv
module wmf_tx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [2:0]        wm_code,
  input  logic              dma_mode,
  input  logic              err_clear,
  output logic              tx_req,
  output logic [CNT_W-1:0]  used_cnt,
  output logic [CNT_W-1:0]  free_cnt,
  output logic              overflow,
  output logic              underflow,
  output logic              config_error
);
  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              full, empty;
  logic              push_ok, pop_ok, ovf_evt, unf_evt;
  logic [DATA_W-1:0] head_data;

  always_comb begin
    push_ok = wr_en && !full;
    pop_ok  = rd_en && !empty;
    ovf_evt = wr_en && full;
    unf_evt = rd_en && empty;
    rd_data = empty ? '0 : head_data;
  end

  wmf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_storage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push_ok),
    .pop       (pop_ok),
    .wr_data   (wr_data),
    .head_data (head_data)
  );

  wmf_level #(.DEPTH(DEPTH)) u_level (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .push     (push_ok),
    .pop      (pop_ok),
    .free_cnt (free_cnt),
    .used_cnt (used_cnt),
    .full     (full),
    .empty    (empty)
  );

  wmf_request #(.DEPTH(DEPTH)) u_request (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .free_cnt     (free_cnt),
    .wm_code      (wm_code),
    .dma_mode     (dma_mode),
    .err_clear    (err_clear),
    .ovf_evt      (ovf_evt),
    .unf_evt      (unf_evt),
    .tx_req       (tx_req),
    .overflow     (overflow),
    .underflow    (underflow),
    .config_error (config_error)
  );

  // R9: a write into a full queue raises the overflow flag.
  a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en && (free_cnt == '0) |=> overflow);
  // R9: a dropped write leaves the full queue full.
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en && !rd_en && (free_cnt == '0) |=> free_cnt == '0);
  // R10: a pop on an empty queue changes no count and raises underflow.
  a_r10_underflow: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en && !wr_en && (used_cnt == '0) |=> underflow && (used_cnt == '0));

endmodule

// File: tb/tb_wmf_tx_fifo.sv
`timescale 1ns/1ps
module tb_wmf_tx_fifo;
  localparam int DW = 32;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, dma_mode = 1'b0, err_clear = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    wm_code = 3'b000;
  logic [DW-1:0] rd_data;
  logic          tx_req, overflow, underflow, config_error;
  logic [4:0]    used_cnt, free_cnt;

  always #4 clk = ~clk;

  wmf_tx_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .wm_code(wm_code), .dma_mode(dma_mode), .err_clear(err_clear),
    .tx_req(tx_req), .used_cnt(used_cnt), .free_cnt(free_cnt), .overflow(overflow),
    .underflow(underflow), .config_error(config_error)
  );

  int          checks = 0;
  int          errors = 0;
  string       tag = "R1";
  bit          model_on = 1'b0;
  logic [DW-1:0] mq[$];
  bit          m_ovf = 0, m_unf = 0, m_cfg = 0;

  // Free entries needed per code, straight from R5, R6 and R7.
  function automatic int need_free(input logic [2:0] c);
    if (c == 3'b100) return 12;
    if (c == 3'b101) return 8;
    if (c == 3'b110) return 4;
    if (c == 3'b111) return 1;
    return 16;
  endfunction

  // Reference model, advanced on every clock from the held inputs.
  always @(posedge clk) begin
    if (model_on) begin
      bit was_full, was_empty;
      was_full  = (mq.size() == DP);
      was_empty = (mq.size() == 0);
      m_ovf = (wr_en && was_full)  || (m_ovf && !err_clear);
      m_unf = (rd_en && was_empty) || (m_unf && !err_clear);
      m_cfg = (dma_mode && wm_code == 3'b111) || (m_cfg && !err_clear);
      if (rd_en && !was_empty) void'(mq.pop_front());
      if (wr_en && !was_full)  mq.push_back(wr_data);
    end
  end

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int      fr;
    logic    er;
    fr = DP - mq.size();
    er = !(dma_mode && wm_code == 3'b111) && (fr >= need_free(wm_code));
    chk("used_cnt", DW'(used_cnt), DW'(mq.size()));
    chk("free_cnt", DW'(free_cnt), DW'(fr));
    chk("rd_data", rd_data, (mq.size() != 0) ? mq[0] : '0);
    chk("tx_req", DW'(tx_req), DW'(er));
    chk("overflow", DW'(overflow), DW'(m_ovf));
    chk("underflow", DW'(underflow), DW'(m_unf));
    chk("config_error", DW'(config_error), DW'(m_cfg));
  endtask

  // Compare at the falling edge, then drive the inputs for the next rising edge.
  task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r,
                     input logic [2:0] c, input logic dm, input logic cl);
    @(negedge clk);
    compare_all();
    wr_en = w; wr_data = d; rd_en = r; wm_code = c; dma_mode = dm; err_clear = cl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    // R1: state right after reset.
    tag = "R1";
    cyc(0, 0, 0, 3'b000, 0, 0);

    // R5, R6, R7: every code on an empty queue.
    tag = "R5";
    for (int c = 0; c < 8; c++) cyc(0, 0, 0, 3'(c), 0, 0);

    // R2, R6: fill one word at a time while cycling codes.
    tag = "R6";
    for (int i = 0; i < DP; i++) begin
      cyc(1, 32'hA500_0000 + 32'(i), 0, 3'(4 + (i % 4)), 0, 0);
      cyc(0, 0, 0, 3'(4 + ((i + 1) % 4)), 0, 0);
    end
    tag = "R7";
    cyc(0, 0, 0, 3'b111, 0, 0);

    // R9: write into a full queue is dropped.
    tag = "R9";
    cyc(1, 32'hDEAD_BEEF, 0, 3'b111, 0, 0);
    cyc(0, 0, 0, 3'b111, 0, 0);

    // R4: write and pop together on a full queue.
    tag = "R4";
    cyc(1, 32'h1111_2222, 1, 3'b110, 0, 0);
    cyc(1, 32'h3333_4444, 1, 3'b110, 0, 0);
    cyc(0, 0, 0, 3'b110, 0, 0);

    // R11: clear the overflow flag.
    tag = "R11";
    cyc(0, 0, 0, 3'b000, 0, 1);
    cyc(0, 0, 0, 3'b000, 0, 0);

    // R3: drain in order, code by code.
    tag = "R3";
    for (int i = 0; i < DP; i++) cyc(0, 0, 1, 3'(4 + (i % 4)), 0, 0);
    cyc(0, 0, 0, 3'b000, 0, 0);

    // R10: pop from empty.
    tag = "R10";
    cyc(0, 0, 1, 3'b000, 0, 0);
    cyc(0, 0, 0, 3'b000, 0, 0);

    // R4: write and pop together on an empty queue.
    tag = "R4";
    cyc(1, 32'hCAFE_0001, 1, 3'b000, 0, 0);
    cyc(1, 32'hCAFE_0002, 1, 3'b000, 0, 0);
    cyc(0, 0, 0, 3'b000, 0, 0);

    // R8: barred code under DMA mode, then leave it.
    tag = "R8";
    cyc(0, 0, 0, 3'b111, 1, 0);
    cyc(0, 0, 0, 3'b111, 1, 0);
    cyc(0, 0, 0, 3'b111, 0, 0);
    cyc(0, 0, 0, 3'b110, 1, 0);

    // R11: clear and new error in the same cycle; event wins.
    tag = "R11";
    cyc(0, 0, 1, 3'b111, 1, 1);
    cyc(0, 0, 0, 3'b000, 0, 1);
    cyc(0, 0, 0, 3'b000, 0, 0);

    // R3: random traffic with varying bias, codes, DMA mode and clears.
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      int bias;
      bias = ((i / 200) % 2 == 0) ? 65 : 35;
      cyc(($urandom % 100) < bias, $urandom, ($urandom % 100) < (100 - bias),
          3'($urandom % 8), ($urandom % 10) == 0, ($urandom % 16) == 0);
    end
    cyc(0, 0, 0, 3'b000, 0, 0);
    @(negedge clk);
    compare_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule